// File: doc/BRIEF.md
# 64-bit Integer ALU

A purely combinational arithmetic logic unit for the execute stage of a small RISC integer pipeline. Two 64-bit operands and a 4-bit operation code select among wrapping add and subtract (each in a signed and an unsigned flavour), four bitwise operations, signed and unsigned set-less-than, and three shifts of operand `a_i`. The result is available in the same cycle, together with a zero flag and a signed overflow flag.

The shift count is six bits wide and is assembled from two ports: `shamt_hi_i` is its most significant bit and `shamt_lo_i` supplies the five bits below it, so any shift from 0 to 63 is possible. The zero flag reflects the result of every operation, so a set-less-than result can feed a branch decision directly. Overflow is reported only for the signed add and subtract.

Top module: `alu64_core`

## Requirements
- R1: Codes 0000 (signed add) and 0001 (unsigned add) give `a_i + b_i` modulo 2^64; codes 0010 (signed subtract) and 0011 (unsigned subtract) give `a_i - b_i` modulo 2^64.
- R2: Codes 0100, 0101, 0110 and 0111 give the bitwise AND, OR, XOR and NOR of `a_i` and `b_i`.
- R3: `overflow_o` is high only for codes 0000 and 0010, and then exactly when the true two's-complement sum or difference lies outside the signed 64-bit range; it is low for every other code.
- R4: Code 1000 gives 1 when `a_i < b_i` as signed two's-complement values, else 0, including when `a_i - b_i` overflows.
- R5: Code 1001 gives 1 when `a_i < b_i` as unsigned values, else 0.
- R6: The shift count is `{shamt_hi_i, shamt_lo_i}` (0 to 63); code 1010 shifts `a_i` left by it, filling with zeros.
- R7: Code 1011 shifts `a_i` right by the shift count, filling with zeros.
- R8: Code 1100 shifts `a_i` right by the shift count, filling with copies of `a_i` bit 63.
- R9: `zero_o` is high exactly when `result_o` is all zeros, for every code.
- R10: Codes 1101, 1110 and 1111 give a zero result, `overflow_o` low and hence `zero_o` high; the shift inputs have no effect on non-shift codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 64 | First operand; the value shifted by shift codes |
| b_i | input | 64 | Second operand |
| op_i | input | 4 | Operation code |
| shamt_lo_i | input | 5 | Low five bits of the shift count |
| shamt_hi_i | input | 1 | Bit 5 of the shift count |
| result_o | output | 64 | Operation result |
| zero_o | output | 1 | High when the result is zero |
| overflow_o | output | 1 | Signed add/subtract overflow |

## Verification
The adder's overflow detection and the signed comparison meet in one cycle whenever a set-less-than is issued with operands whose difference overflows, such as the most negative value against a positive one; the bench sweeps boundary operand pairs through every code so the comparison is judged against exact 65-bit arithmetic while the overflow flag is required to stay low. Zero detection and overflow also coincide when a signed add wraps to exactly zero (most negative plus itself), which the sweep covers and judges against both flags. Shifts are swept over all 64 counts, and non-shift codes are driven with a nonzero count to show it is ignored.

// File: rtl/alu64_pkg.sv
package alu64_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_ADDU = 4'h1,
    OP_SUB  = 4'h2,
    OP_SUBU = 4'h3,
    OP_AND  = 4'h4,
    OP_OR   = 4'h5,
    OP_XOR  = 4'h6,
    OP_NOR  = 4'h7,
    OP_SLT  = 4'h8,
    OP_SLTU = 4'h9,
    OP_SLL  = 4'hA,
    OP_SRL  = 4'hB,
    OP_SRA  = 4'hC
  } alu_op_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_NOR = 2'd3
  } logic_fn_e;
endpackage

// File: rtl/alu64_addsub.sv
module alu64_addsub #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,
  output logic         lt_s_o,
  output logic         lt_u_o
);
  logic [W-1:0] b_eff;
  logic         carry;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign {carry, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};

  // same-sign inputs, different-sign result
  assign ovf_o  = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
  // true sign of a-b survives overflow
  assign lt_s_o = sum_o[W-1] ^ ovf_o;
  // no carry out of a + ~b + 1 means a borrow
  assign lt_u_o = ~carry;
endmodule

// File: rtl/alu64_logic.sv
module alu64_logic
  import alu64_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_fn_e    fn_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    unique case (fn_i)
      LG_AND:  y_o = a_i & b_i;
      LG_OR:   y_o = a_i | b_i;
      LG_XOR:  y_o = a_i ^ b_i;
      default: y_o = ~(a_i | b_i);
    endcase
  end
endmodule

// File: rtl/alu64_shift.sv
module alu64_shift #(
  parameter int W  = 64,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  a_i,
  input  logic [SW-1:0] amt_i,
  input  logic          arith_i,
  output logic [W-1:0]  left_o,
  output logic [W-1:0]  right_o
);
  logic [W-1:0] l_stg [SW+1];
  logic [W-1:0] r_stg [SW+1];
  logic         fill;

  assign fill     = arith_i & a_i[W-1];
  assign l_stg[0] = a_i;
  assign r_stg[0] = a_i;

  for (genvar i = 0; i < SW; i++) begin : g_stage
    localparam int S = 1 << i;
    assign l_stg[i+1] = amt_i[i] ? {l_stg[i][W-1-S:0], {S{1'b0}}} : l_stg[i];
    assign r_stg[i+1] = amt_i[i] ? {{S{fill}}, r_stg[i][W-1:S]}   : r_stg[i];
  end

  assign left_o  = l_stg[SW];
  assign right_o = r_stg[SW];
endmodule

// File: rtl/alu64_core.sv
module alu64_core
  import alu64_pkg::*;
#(
  parameter int W    = 64,
  parameter int LO_W = 5
) (
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [3:0]      op_i,
  input  logic [LO_W-1:0] shamt_lo_i,
  input  logic            shamt_hi_i,
  output logic [W-1:0]    result_o,
  output logic            zero_o,
  output logic            overflow_o
);
  localparam int SW = LO_W + 1;

  alu_op_e      op;
  logic         sub_mode;
  logic [W-1:0] sum, lg_y, sh_l, sh_r;
  logic         ovf_raw, lt_s, lt_u;
  logic [SW-1:0] amt;

  assign op       = alu_op_e'(op_i);
  assign amt      = {shamt_hi_i, shamt_lo_i};
  assign sub_mode = (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);

  alu64_addsub #(.W(W)) u_addsub (
    .a_i(a_i), .b_i(b_i), .sub_i(sub_mode),
    .sum_o(sum), .ovf_o(ovf_raw), .lt_s_o(lt_s), .lt_u_o(lt_u)
  );

  alu64_logic #(.W(W)) u_logic (
    .a_i(a_i), .b_i(b_i), .fn_i(logic_fn_e'(op_i[1:0])), .y_o(lg_y)
  );

  alu64_shift #(.W(W), .SW(SW)) u_shift (
    .a_i(a_i), .amt_i(amt), .arith_i(op == OP_SRA),
    .left_o(sh_l), .right_o(sh_r)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result_o = sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR:    result_o = lg_y;
      OP_SLT:                           result_o = {{(W-1){1'b0}}, lt_s};
      OP_SLTU:                          result_o = {{(W-1){1'b0}}, lt_u};
      OP_SLL:                           result_o = sh_l;
      OP_SRL, OP_SRA:                   result_o = sh_r;
      default:                          result_o = '0;
    endcase
  end

  assign zero_o     = ~|result_o;
  assign overflow_o = ovf_raw && ((op == OP_ADD) || (op == OP_SUB));

  always_comb begin
    if (op != OP_ADD && op != OP_SUB)
      p_no_overflow_r3: assert (!overflow_o);
    if (overflow_o && op == OP_ADD)
      p_ovf_add_r3: assert (a_i[W-1] == b_i[W-1] && result_o[W-1] != a_i[W-1]);
    if (op == OP_SLT || op == OP_SLTU)
      p_slt_onebit_r4: assert (result_o[W-1:1] == '0);
    if (op_i > 4'hC)
      p_unused_r10: assert (result_o == '0 && zero_o && !overflow_o);
    if ((op == OP_SLL || op == OP_SRL || op == OP_SRA) && amt == '0)
      p_shift_none_r6: assert (result_o == a_i);
  end
endmodule

// File: tb/sim_alu64_core.sv
module sim_alu64_core;
  logic        clk = 1'b0;
  logic [63:0] a, b;
  logic [3:0]  op;
  logic [4:0]  sh_lo;
  logic        sh_hi;
  logic [63:0] res;
  logic        zf, of;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu64_core u0 (
    .a_i(a), .b_i(b), .op_i(op), .shamt_lo_i(sh_lo), .shamt_hi_i(sh_hi),
    .result_o(res), .zero_o(zf), .overflow_o(of)
  );

  function automatic logic [63:0] pick(int k);
    case (k)
      0: return 64'h0;
      1: return 64'h1;
      2: return 64'hFFFF_FFFF_FFFF_FFFF;
      3: return 64'h7FFF_FFFF_FFFF_FFFF;
      4: return 64'h8000_0000_0000_0000;
      5: return 64'h8000_0000_0000_0001;
      6: return 64'h0123_4567_89AB_CDEF;
      7: return 64'hF0F0_0000_FFFF_1234;
      8: return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hC3A5_5A3C_0F0F_E001;
    endcase
  endfunction

  function automatic string tag(logic [3:0] o);
    case (o)
      4'h0, 4'h1, 4'h2, 4'h3: return "R1/R3/R9";
      4'h4, 4'h5, 4'h6, 4'h7: return "R2/R9";
      4'h8: return "R4";
      4'h9: return "R5";
      4'hA: return "R6";
      4'hB: return "R7";
      4'hC: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic model(input logic [63:0] x, input logic [63:0] y, input logic [3:0] o,
                       input int s, output logic [63:0] r, output logic v);
    logic signed [64:0] wide;
    v = 1'b0;
    case (o)
      4'h0, 4'h1: begin
        r = x + y;
        wide = {x[63], x} + {y[63], y};
        v = (o == 4'h0) && (wide > 65'sh0_7FFF_FFFF_FFFF_FFFF || wide < -65'sh0_8000_0000_0000_0000);
      end
      4'h2, 4'h3: begin
        r = x - y;
        wide = {x[63], x} - {y[63], y};
        v = (o == 4'h2) && (wide > 65'sh0_7FFF_FFFF_FFFF_FFFF || wide < -65'sh0_8000_0000_0000_0000);
      end
      4'h4: r = x & y;
      4'h5: r = x | y;
      4'h6: r = x ^ y;
      4'h7: r = ~(x | y);
      4'h8: r = {63'd0, $signed(x) < $signed(y)};
      4'h9: r = {63'd0, x < y};
      4'hA: r = x << s;
      4'hB: r = x >> s;
      4'hC: r = $signed(x) >>> s;
      default: r = 64'd0;
    endcase
  endtask

  task automatic apply(input logic [63:0] x, input logic [63:0] y, input logic [3:0] o, input int s);
    logic [63:0] er;
    logic        ev;
    @(posedge clk);
    a = x; b = y; op = o; sh_lo = s[4:0]; sh_hi = s[5];
    model(x, y, o, s, er, ev);
    @(negedge clk);
    checks++;
    if (res !== er || of !== ev || zf !== (er == 64'd0)) begin
      errors++;
      $display("FAIL %s op=%h a=%h b=%h sh=%0d got r=%h z=%b v=%b exp r=%h z=%b v=%b",
               tag(o), o, x, y, s, res, zf, of, er, er == 64'd0, ev);
    end
  endtask

  initial begin
    a = '0; b = '0; op = '0; sh_lo = '0; sh_hi = 1'b0;
    // idle inputs: R9 zero result flags zero
    apply(64'd0, 64'd0, 4'h0, 0);
    // non-shift codes with a nonzero count to show it is ignored (R10)
    for (int o = 0; o < 16; o++)
      if (o < 10 || o > 12)
        for (int i = 0; i < 10; i++)
          for (int j = 0; j < 10; j++)
            apply(pick(i), pick(j), o[3:0], 45);
    // shifts over every count R6 R7 R8
    for (int o = 10; o <= 12; o++)
      for (int i = 0; i < 10; i++)
        for (int s = 0; s < 64; s++)
          apply(pick(i), pick((i + s) % 10), o[3:0], s);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule